// File: doc/BRIEF.md
# Debug-Mode Entry and Halted-Trap Steering Controller

This controller decides, cycle by cycle, whether a hart enters debug mode and where its program counter goes while it is halted. When a debug-entry request with a nonzero reason code arrives and the hart is running, it redirects the fetch stream to a fixed debug-ROM entry point and forces machine privilege in that same cycle. On the following clock edge it captures the reason code, the prior privilege level and the interrupted PC. While halted, it keeps every interrupt from being taken. It steers any trap to one of two fixed ROM addresses: a breakpoint returns to the entry point, and every other trap goes to a separate trap vector.

The controller has two states. In RUN the captured reason is 0 and interrupts may be taken. In HALTED the captured reason is nonzero. The only transition is ENTER, from RUN to HALTED, which fires on a valid entry request. HALTED has no outgoing transition inside this block; only reset returns it to RUN. Outside redirects, the PC and privilege pass through unchanged, so the block can sit directly in front of the PC and privilege registers of the core.

Top module: `dbg_entry_ctl`

## Requirements
- R1: In RUN, a request `enter_req`=1 with `enter_why`≠0 drives, in that same cycle, `pc_redirect`=1, `pc_next`=ENTRY_ADDR (default 0x800) and `prv_next`=3 (machine).
- R2: On the clock edge that ends an R1 cycle, `halt_why` takes `enter_why`, `halt_prv` takes `cur_prv` and `saved_pc` takes `cur_pc`; the block is then HALTED.
- R3: While `halt_why`≠0, `irq_take` stays 0 whatever `irq_pend` holds.
- R4: In RUN, with no entry this cycle and `irq_pend`≠0, `irq_take`=1 and `irq_code` has bit XLEN-1 set, zeros in between, and in its low bits the index of the lowest set bit of `irq_pend`.
- R5: While HALTED, `trap_fire`=1 with `trap_code`=3 (breakpoint) gives `pc_redirect`=1, `pc_next`=ENTRY_ADDR and `prv_next`=3.
- R6: While HALTED, `trap_fire`=1 with any `trap_code` other than 3 gives `pc_redirect`=1, `pc_next`=TRAP_ADDR (default 0x808) and `prv_next`=3.
- R7: An entry request in the same cycle as a trap or pending interrupts wins. The PC goes to ENTRY_ADDR, `irq_take`=0, and the capture of R2 follows.
- R8: While HALTED, an entry request is ignored. There is no redirect, and `halt_why`, `halt_prv` and `saved_pc` keep their values.
- R9: An entry request with `enter_why`=0 is ignored. There is no redirect and the block stays in RUN.
- R10: After reset, `halt_why`=0, `halt_prv`=0 and `saved_pc`=0. With no redirect, `pc_next`=`cur_pc` and `prv_next`=`cur_prv`.
- R11: In RUN, a trap (`trap_fire`=1) does not cause a redirect, so `pc_redirect`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request to enter debug mode |
| enter_why | input | 3 | Reason code for the entry request |
| cur_pc | input | XLEN | Current program counter |
| cur_prv | input | 2 | Current privilege level |
| trap_fire | input | 1 | A trap is being taken this cycle |
| trap_code | input | TRAP_W | Cause code of that trap |
| irq_pend | input | NIRQ | Pending and enabled interrupts |
| pc_next | output | XLEN | PC for the next cycle |
| prv_next | output | 2 | Privilege for the next cycle |
| pc_redirect | output | 1 | This block overrides the PC this cycle |
| halt_why | output | 3 | Captured debug reason (0 = running) |
| halt_prv | output | 2 | Privilege captured on entry |
| saved_pc | output | XLEN | PC captured on entry |
| irq_take | output | 1 | An interrupt is taken this cycle |
| irq_code | output | XLEN | Cause of the taken interrupt |

## Verification
If the mode state is wrong, it shows up within the same cycle. A stuck RUN lets `irq_take` rise while `halt_why` is nonzero. A stuck HALTED blocks interrupts and redirects traps that should pass through. Faults in the capture path show one edge after ENTER, as wrong values in `halt_why`, `halt_prv` or `saved_pc`, and those values must then stay frozen on every later cycle. A swapped ROM address or a wrong breakpoint decode shows up in `pc_next` in the very cycle of the trap.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } dbg_state_e;

    localparam logic [1:0] PRV_MACHINE = 2'd3;
    localparam int         CAUSE_BKPT  = 3;
endpackage

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int TRAP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic [2:0]        enter_why,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_prv,
    input  logic              trap_fire,
    input  logic [TRAP_W-1:0] trap_code,
    output logic              do_enter,
    output logic              do_dbg_trap,
    output logic              trap_is_bkpt,
    output logic              irq_allow,
    output logic [2:0]        halt_why,
    output logic [1:0]        halt_prv,
    output logic [XLEN-1:0]   saved_pc
);
    dbg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // capture registers, written only on ENTER
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_why <= 3'd0;
            halt_prv <= 2'd0;
            saved_pc <= '0;
        end else if (do_enter) begin
            halt_why <= enter_why;
            halt_prv <= cur_prv;
            saved_pc <= cur_pc;
        end
    end

    assign trap_is_bkpt = (trap_code == TRAP_W'(CAUSE_BKPT));

    // next state and decode outputs
    always_comb begin
        state_d     = state_q;
        do_enter    = 1'b0;
        do_dbg_trap = 1'b0;
        irq_allow   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (enter_req && (enter_why != 3'd0)) begin
                    do_enter = 1'b1;
                    state_d  = ST_HALT;
                end else begin
                    irq_allow = 1'b1;
                end
            end
            ST_HALT: begin
                do_dbg_trap = trap_fire;
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/dbg_redirect.sv
module dbg_redirect
    import dbg_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0800,
    parameter logic [XLEN-1:0] TRAP_ADDR  = 32'h0000_0808
) (
    input  logic            do_enter,
    input  logic            do_dbg_trap,
    input  logic            trap_is_bkpt,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_prv,
    output logic            pc_redirect,
    output logic [XLEN-1:0] pc_next,
    output logic [1:0]      prv_next
);
    always_comb begin
        pc_redirect = do_enter | do_dbg_trap;
        pc_next     = cur_pc;
        prv_next    = cur_prv;
        if (do_enter) begin
            pc_next  = ENTRY_ADDR;
            prv_next = PRV_MACHINE;
        end else if (do_dbg_trap) begin
            pc_next  = trap_is_bkpt ? ENTRY_ADDR : TRAP_ADDR;
            prv_next = PRV_MACHINE;
        end
    end
endmodule

// File: rtl/dbg_irq_pick.sv
module dbg_irq_pick #(
    parameter int XLEN = 32,
    parameter int NIRQ = 16
) (
    input  logic [NIRQ-1:0] irq_pend,
    input  logic            irq_allow,
    output logic            irq_take,
    output logic [XLEN-1:0] irq_code
);
    localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [IDXW-1:0] low_idx;

    // lowest set bit wins: scan downward so the last hit is the lowest index
    always_comb begin
        low_idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq_pend[i]) low_idx = IDXW'(i);
        end
    end

    always_comb begin
        irq_take = irq_allow && (irq_pend != '0);
        irq_code = '0;
        if (irq_take) begin
            irq_code[XLEN-1]   = 1'b1;
            irq_code[IDXW-1:0] = low_idx;
        end
    end
endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl #(
    parameter int              XLEN       = 32,
    parameter int              NIRQ       = 16,
    parameter int              TRAP_W     = 5,
    parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0800,
    parameter logic [XLEN-1:0] TRAP_ADDR  = 32'h0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic [2:0]        enter_why,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_prv,
    input  logic              trap_fire,
    input  logic [TRAP_W-1:0] trap_code,
    input  logic [NIRQ-1:0]   irq_pend,
    output logic [XLEN-1:0]   pc_next,
    output logic [1:0]        prv_next,
    output logic              pc_redirect,
    output logic [2:0]        halt_why,
    output logic [1:0]        halt_prv,
    output logic [XLEN-1:0]   saved_pc,
    output logic              irq_take,
    output logic [XLEN-1:0]   irq_code
);
    logic do_enter, do_dbg_trap, trap_is_bkpt, irq_allow;

    dbg_mode_fsm #(.XLEN(XLEN), .TRAP_W(TRAP_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .enter_req(enter_req), .enter_why(enter_why),
        .cur_pc(cur_pc), .cur_prv(cur_prv),
        .trap_fire(trap_fire), .trap_code(trap_code),
        .do_enter(do_enter), .do_dbg_trap(do_dbg_trap),
        .trap_is_bkpt(trap_is_bkpt), .irq_allow(irq_allow),
        .halt_why(halt_why), .halt_prv(halt_prv), .saved_pc(saved_pc)
    );

    dbg_redirect #(.XLEN(XLEN), .ENTRY_ADDR(ENTRY_ADDR), .TRAP_ADDR(TRAP_ADDR)) redir_i (
        .do_enter(do_enter), .do_dbg_trap(do_dbg_trap), .trap_is_bkpt(trap_is_bkpt),
        .cur_pc(cur_pc), .cur_prv(cur_prv),
        .pc_redirect(pc_redirect), .pc_next(pc_next), .prv_next(prv_next)
    );

    dbg_irq_pick #(.XLEN(XLEN), .NIRQ(NIRQ)) irq_i (
        .irq_pend(irq_pend), .irq_allow(irq_allow),
        .irq_take(irq_take), .irq_code(irq_code)
    );
endmodule

// File: rtl/dbg_entry_ctl_chk.sv
module dbg_entry_ctl_chk #(
    parameter int              XLEN       = 32,
    parameter int              NIRQ       = 16,
    parameter int              TRAP_W     = 5,
    parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0800,
    parameter logic [XLEN-1:0] TRAP_ADDR  = 32'h0000_0808
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_req,
    input logic [2:0]        enter_why,
    input logic [XLEN-1:0]   cur_pc,
    input logic [1:0]        cur_prv,
    input logic              trap_fire,
    input logic [TRAP_W-1:0] trap_code,
    input logic [NIRQ-1:0]   irq_pend,
    input logic [XLEN-1:0]   pc_next,
    input logic [1:0]        prv_next,
    input logic              pc_redirect,
    input logic [2:0]        halt_why,
    input logic [1:0]        halt_prv,
    input logic [XLEN-1:0]   saved_pc,
    input logic              irq_take,
    input logic [XLEN-1:0]   irq_code
);
    assert_enter_redirect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why == 3'd0 && enter_req && enter_why != 3'd0)
        |-> (pc_redirect && pc_next == ENTRY_ADDR && prv_next == 2'd3));

    assert_enter_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why == 3'd0 && enter_req && enter_why != 3'd0)
        |=> (halt_why == $past(enter_why) && halt_prv == $past(cur_prv)
             && saved_pc == $past(cur_pc)));

    assert_no_irq_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why != 3'd0) |-> !irq_take);

    assert_irq_code_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_code[XLEN-1] && irq_pend != '0));

    assert_bkpt_to_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why != 3'd0 && trap_fire && trap_code == TRAP_W'(3))
        |-> (pc_redirect && pc_next == ENTRY_ADDR));

    assert_trap_to_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why != 3'd0 && trap_fire && trap_code != TRAP_W'(3))
        |-> (pc_redirect && pc_next == TRAP_ADDR));

    assert_halted_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why != 3'd0) |=> ($stable(halt_why) && $stable(halt_prv) && $stable(saved_pc)));

    assert_run_trap_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_why == 3'd0 && !enter_req) |-> !pc_redirect);
endmodule

bind dbg_entry_ctl dbg_entry_ctl_chk #(
    .XLEN(XLEN), .NIRQ(NIRQ), .TRAP_W(TRAP_W),
    .ENTRY_ADDR(ENTRY_ADDR), .TRAP_ADDR(TRAP_ADDR)
) chk_i (.*);

// File: tb/dbg_entry_ctl_tb_top.sv
`timescale 1ns/1ps
module dbg_entry_ctl_tb_top;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;
    localparam int TRAP_W = 5;
    localparam logic [31:0] ENTRY = 32'h0000_0800;
    localparam logic [31:0] TVEC  = 32'h0000_0808;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enter_req = 1'b0;
    logic [2:0]        enter_why = '0;
    logic [XLEN-1:0]   cur_pc = '0;
    logic [1:0]        cur_prv = '0;
    logic              trap_fire = 1'b0;
    logic [TRAP_W-1:0] trap_code = '0;
    logic [NIRQ-1:0]   irq_pend = '0;
    logic [XLEN-1:0]   pc_next, saved_pc, irq_code;
    logic [1:0]        prv_next, halt_prv;
    logic              pc_redirect, irq_take;
    logic [2:0]        halt_why;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_entry_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .enter_req(enter_req), .enter_why(enter_why),
        .cur_pc(cur_pc), .cur_prv(cur_prv),
        .trap_fire(trap_fire), .trap_code(trap_code), .irq_pend(irq_pend),
        .pc_next(pc_next), .prv_next(prv_next), .pc_redirect(pc_redirect),
        .halt_why(halt_why), .halt_prv(halt_prv), .saved_pc(saved_pc),
        .irq_take(irq_take), .irq_code(irq_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        enter_req = 1'b0; enter_why = '0; trap_fire = 1'b0;
        trap_code = '0; irq_pend = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R10: reset values and pass-through
    task automatic t_reset();
        do_reset();
        cur_pc = 32'hABCD_0010; cur_prv = 2'd1;
        #1;
        chk("R10 halt_why", 64'(halt_why), 64'd0);
        chk("R10 halt_prv", 64'(halt_prv), 64'd0);
        chk("R10 saved_pc", 64'(saved_pc), 64'd0);
        chk("R10 redirect", 64'(pc_redirect), 64'd0);
        chk("R10 pc_next",  64'(pc_next), 64'hABCD_0010);
        chk("R10 prv_next", 64'(prv_next), 64'd1);
    endtask

    // R4, R9, R11: behaviour while running
    task automatic t_running();
        do_reset();
        @(negedge clk);
        irq_pend = 16'b0000_0000_0010_1000; #1;
        chk("R4 take a",  64'(irq_take), 64'd1);
        chk("R4 code a",  64'(irq_code), 64'h8000_0003);
        irq_pend = 16'h8000; #1;
        chk("R4 code top", 64'(irq_code), 64'h8000_000F);
        irq_pend = 16'h0001; #1;
        chk("R4 code low", 64'(irq_code), 64'h8000_0000);
        irq_pend = '0; #1;
        chk("R4 none", 64'(irq_take), 64'd0);
        trap_fire = 1'b1; trap_code = 5'd3; cur_pc = 32'h40; #1;
        chk("R11 no redirect", 64'(pc_redirect), 64'd0);
        chk("R11 pc pass", 64'(pc_next), 64'h40);
        trap_fire = 1'b0;
        enter_req = 1'b1; enter_why = 3'd0; #1;
        chk("R9 no redirect", 64'(pc_redirect), 64'd0);
        @(posedge clk); #1;
        chk("R9 stays run", 64'(halt_why), 64'd0);
        chk("R9 dpc kept", 64'(saved_pc), 64'd0);
        @(negedge clk); idle_inputs();
    endtask

    // R1, R2, R7: entry wins over trap and interrupts
    task automatic t_enter();
        do_reset();
        @(negedge clk);
        cur_pc = 32'h1234_5670; cur_prv = 2'd1;
        enter_req = 1'b1; enter_why = 3'd2;
        trap_fire = 1'b1; trap_code = 5'd5; irq_pend = 16'h00FF;
        #1;
        chk("R1 redirect", 64'(pc_redirect), 64'd1);
        chk("R1/R7 pc_next", 64'(pc_next), 64'(ENTRY));
        chk("R1 prv_next", 64'(prv_next), 64'd3);
        chk("R7 irq blocked", 64'(irq_take), 64'd0);
        @(posedge clk); #1;
        chk("R2 halt_why", 64'(halt_why), 64'd2);
        chk("R2 halt_prv", 64'(halt_prv), 64'd1);
        chk("R2/R7 saved_pc", 64'(saved_pc), 64'h1234_5670);
        @(negedge clk); idle_inputs();
    endtask

    // R3, R5, R6, R8: behaviour while halted (continues from t_enter)
    task automatic t_halted();
        @(negedge clk);
        irq_pend = 16'h0001; cur_pc = 32'h900; cur_prv = 2'd3; #1;
        chk("R3 irq masked", 64'(irq_take), 64'd0);
        trap_fire = 1'b1; trap_code = 5'd3; #1;
        chk("R5 redirect", 64'(pc_redirect), 64'd1);
        chk("R5 pc entry", 64'(pc_next), 64'(ENTRY));
        chk("R5 prv", 64'(prv_next), 64'd3);
        trap_code = 5'd5; #1;
        chk("R6 pc vec", 64'(pc_next), 64'(TVEC));
        trap_code = 5'd2; #1;
        chk("R6 pc vec b", 64'(pc_next), 64'(TVEC));
        trap_fire = 1'b0; irq_pend = '0;
        enter_req = 1'b1; enter_why = 3'd4; cur_pc = 32'hDEAD_0000; cur_prv = 2'd0; #1;
        chk("R8 no redirect", 64'(pc_redirect), 64'd0);
        @(posedge clk); #1;
        chk("R8 why kept", 64'(halt_why), 64'd2);
        chk("R8 prv kept", 64'(halt_prv), 64'd1);
        chk("R8 dpc kept", 64'(saved_pc), 64'h1234_5670);
        @(negedge clk); idle_inputs();
    endtask

    initial begin
        t_reset();
        t_running();
        t_enter();
        t_halted();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule